// File: doc/BRIEF.md
# Variable Pulse Width Bus Transmitter

This block turns a stream of bytes into symbols on a single-wire bus that uses variable pulse width coding. Each bit is one interval on the bus, and the bus level flips from one bit to the next. A bit lasts either a short or a long time. Which one depends on the bit value and on the level the bit is driven at. A free-running microsecond strobe (`us_tick`) sets the time base, so every duration below is a count of ticks.

A frame begins once a byte sits in the one-byte input buffer and the sensed bus (`bus_in`) has stayed passive for the inter-frame gap. The block first drives an active start symbol. It then sends each byte most significant bit first, and every byte begins at the passive level. After the byte flagged last, or after running out of bytes, it holds the bus passive through end-of-data and end-of-frame, then returns to idle. A quarter-time mode shortens every duration by a factor of four.

The controller states are IDLE, WAIT_IFS, SOF, BIT, EOD and EOF. The transitions are:
- IDLE to WAIT_IFS when the buffer fills.
- WAIT_IFS to SOF once the bus is idle.
- SOF to BIT when the start symbol expires.
- BIT to BIT on each bit expiry, including the step into the next byte.
- BIT to EOD after the final bit of a frame.
- EOD to EOF when end-of-data expires.
- EOF to IDLE when end-of-frame expires.

Top module: `vpw_tx`

## Requirements
- R1: After reset, `bus_out` is 0 (passive), `tx_busy` is 0 and `s_ready` is 1.
- R2: A byte is taken on a clock edge where `s_valid` and `s_ready` are both 1. `s_ready` is 0 whenever the one-byte buffer is full, and it goes 0 the cycle after an accept.
- R3: SOF starts only after `bus_in` has been passive for 300 consecutive ticks (75 in quarter-time mode), counted from the last tick at which it was seen active. The same holds when `bus_in` is held active by another node.
- R4: A frame opens with SOF at `bus_out`=1 for 200 ticks. `tx_busy` rises together with it.
- R5: Bits go out most significant bit first with alternating levels. The first bit of every byte is at level 0.
- R6: A bit's duration is long (128 ticks) when bit value XOR level is 1, and short (64 ticks) otherwise. So passive 1 and active 0 are long, and passive 0 and active 1 are short.
- R7: After the final bit, the bus stays passive for 200 ticks of end-of-data plus 80 ticks of end-of-frame (280 in total), and then `tx_busy` falls.
- R8: When `quad_mode` is 1 at frame start, every duration is divided by four for the whole frame. Changing `quad_mode` during the frame has no effect on that frame.
- R9: Bytes continue in one frame until a byte with `s_last`=1 is sent. If the buffer is empty at a byte boundary, the frame ends there.
- R10: During a frame, `bus_out` changes only on the clock edge at which a tick is seen.
- R11: `bus_out` is 0 whenever `tx_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe marking each microsecond |
| quad_mode | input | 1 | 1 selects quarter-length symbols, sampled at frame start |
| bus_in | input | 1 | Sensed bus level, 1 = active |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Buffer can take a byte |
| bus_out | output | 1 | Driven bus level, 1 = active |
| tx_busy | output | 1 | High from SOF until EOF ends |

## Verification
Single-byte frames use values with equal neighbouring bits (00, FF), alternating bits (A5, 5A, 96) and mixed runs (3C, 81, C6), in both speed modes. Together these produce all four value-and-level pairs, so a swapped short/long choice or a wrong starting level shows up. A three-byte frame shows that the second and third bytes restart at the passive level. An underrun frame and an end-of-frame tail show where a frame stops. The inter-frame gap is measured after a previous frame and after another node releases the bus. Flipping `quad_mode` in mid-frame shows whether the speed mode is held for the whole frame.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_IFS,
        ST_SOF,
        ST_BIT,
        ST_EOD,
        ST_EOF
    } vpw_state_t;

    function automatic int unsigned vpw_max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vpw_idle_mon.sv
// Counts passive microseconds on the sensed bus; flags an idle bus once
// the inter-frame gap has elapsed.
module vpw_idle_mon #(
    parameter int unsigned IFS_US = 300,
    parameter int unsigned QSHIFT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic quad,
    input  logic bus_in,
    output logic idle
);
    localparam int unsigned CW = $clog2(IFS_US + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = quad ? CW'(IFS_US >> QSHIFT) : CW'(IFS_US);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bus_in) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign idle = (cnt_q >= limit);

endmodule

// File: rtl/vpw_sym_timer.sv
// Down counter in ticks; expire pulses on the tick that ends a symbol.
module vpw_sym_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign expire = tick && (cnt_q == CW'(1));

endmodule

// File: rtl/vpw_byte_path.sv
// One-byte holding buffer feeding an MSB-first shift register.
module vpw_byte_path #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_valid,
    input  logic [W-1:0] s_data,
    input  logic         s_last,
    output logic         s_ready,
    input  logic         take,
    input  logic         shift,
    output logic         hold_full,
    output logic         hold_msb,
    output logic         cur_bit,
    output logic         next_bit,
    output logic         byte_end,
    output logic         cur_last
);
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  hold_q;
    logic          hold_last_q;
    logic          hold_full_q;
    logic [W-1:0]  sh_q;
    logic          sh_last_q;
    logic [IW-1:0] idx_q;
    logic          accept;

    assign s_ready = !hold_full_q;
    assign accept  = s_valid && !hold_full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_last_q <= 1'b0;
            hold_full_q <= 1'b0;
        end else if (accept) begin
            hold_q      <= s_data;
            hold_last_q <= s_last;
            hold_full_q <= 1'b1;
        end else if (take) begin
            hold_full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_last_q <= 1'b0;
            idx_q     <= '0;
        end else if (take) begin
            sh_q      <= hold_q;
            sh_last_q <= hold_last_q;
            idx_q     <= '0;
        end else if (shift) begin
            sh_q      <= {sh_q[W-2:0], 1'b0};
            idx_q     <= idx_q + IW'(1);
        end
    end

    assign hold_full = hold_full_q;
    assign hold_msb  = hold_q[W-1];
    assign cur_bit   = sh_q[W-1];
    assign next_bit  = sh_q[W-2];
    assign byte_end  = (idx_q == IW'(W - 1));
    assign cur_last  = sh_last_q;

endmodule

// File: rtl/vpw_tx.sv
module vpw_tx #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned SHORT_US = 64,
    parameter int unsigned LONG_US  = 128,
    parameter int unsigned SOF_US   = 200,
    parameter int unsigned EOD_US   = 200,
    parameter int unsigned EOF_US   = 80,
    parameter int unsigned IFS_US   = 300,
    parameter int unsigned QSHIFT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              quad_mode,
    input  logic              bus_in,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              bus_out,
    output logic              tx_busy
);
    import vpw_pkg::*;

    localparam int unsigned MAX_US = vpw_max2(vpw_max2(LONG_US, SOF_US),
                                              vpw_max2(EOD_US, EOF_US));
    localparam int unsigned CW     = $clog2(MAX_US + 1);

    vpw_state_t    st_q, st_nxt;
    logic          lvl_q, lvl_nxt;
    logic          quad_q, quad_nxt;
    logic          bus_q, busy_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_len;
    logic          expire;
    logic          take, shift;
    logic          hold_full, hold_msb, cur_bit, next_bit, byte_end, cur_last;
    logic          bus_idle;

    function automatic logic [CW-1:0] scale(input int unsigned us, input logic q);
        return q ? CW'(us >> QSHIFT) : CW'(us);
    endfunction

    // long when value XOR level is 1
    function automatic logic [CW-1:0] bit_len(input logic b, input logic act, input logic q);
        return scale((b ^ act) ? LONG_US : SHORT_US, q);
    endfunction

    vpw_idle_mon #(
        .IFS_US (IFS_US),
        .QSHIFT (QSHIFT)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .quad   (quad_mode),
        .bus_in (bus_in),
        .idle   (bus_idle)
    );

    vpw_sym_timer #(
        .CW (CW)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (expire)
    );

    vpw_byte_path #(
        .W (BYTE_W)
    ) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .take      (take),
        .shift     (shift),
        .hold_full (hold_full),
        .hold_msb  (hold_msb),
        .cur_bit   (cur_bit),
        .next_bit  (next_bit),
        .byte_end  (byte_end),
        .cur_last  (cur_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            lvl_q  <= 1'b0;
            quad_q <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            lvl_q  <= lvl_nxt;
            quad_q <= quad_nxt;
        end
    end

    // next state and datapath control
    always_comb begin
        st_nxt   = st_q;
        lvl_nxt  = lvl_q;
        quad_nxt = quad_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        take     = 1'b0;
        shift    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (hold_full) begin
                    st_nxt = ST_WAIT_IFS;
                end
            end
            ST_WAIT_IFS: begin
                if (bus_idle) begin
                    st_nxt   = ST_SOF;
                    take     = 1'b1;
                    quad_nxt = quad_mode;
                    tmr_load = 1'b1;
                    tmr_len  = scale(SOF_US, quad_mode);
                end
            end
            ST_SOF: begin
                if (expire) begin
                    st_nxt   = ST_BIT;
                    lvl_nxt  = 1'b0;
                    tmr_load = 1'b1;
                    tmr_len  = bit_len(cur_bit, 1'b0, quad_q);
                end
            end
            ST_BIT: begin
                if (expire) begin
                    if (!byte_end) begin
                        shift    = 1'b1;
                        lvl_nxt  = !lvl_q;
                        tmr_load = 1'b1;
                        tmr_len  = bit_len(next_bit, !lvl_q, quad_q);
                    end else if (!cur_last && hold_full) begin
                        take     = 1'b1;
                        lvl_nxt  = 1'b0;
                        tmr_load = 1'b1;
                        tmr_len  = bit_len(hold_msb, 1'b0, quad_q);
                    end else begin
                        st_nxt   = ST_EOD;
                        tmr_load = 1'b1;
                        tmr_len  = scale(EOD_US, quad_q);
                    end
                end
            end
            ST_EOD: begin
                if (expire) begin
                    st_nxt   = ST_EOF;
                    tmr_load = 1'b1;
                    tmr_len  = scale(EOF_US, quad_q);
                end
            end
            ST_EOF: begin
                if (expire) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
    end

    // outputs, registered from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            bus_q  <= (st_nxt == ST_SOF) || ((st_nxt == ST_BIT) && lvl_nxt);
            busy_q <= (st_nxt == ST_SOF) || (st_nxt == ST_BIT) ||
                      (st_nxt == ST_EOD) || (st_nxt == ST_EOF);
        end
    end

    assign bus_out = bus_q;
    assign tx_busy = busy_q;

endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic us_tick,
    input logic s_valid,
    input logic s_ready,
    input logic bus_out,
    input logic tx_busy,
    input logic bus_idle
);
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready); // R2

    AST_IFS_BEFORE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(bus_idle)); // R3

    AST_SOF_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> bus_out); // R4

    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bus_out) && $past(tx_busy)) |-> $past(us_tick)); // R10

    AST_PASSIVE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !bus_out); // R11

endmodule

bind vpw_tx vpw_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .bus_out  (bus_out),
    .tx_busy  (tx_busy),
    .bus_idle (bus_idle)
);

// File: tb/tb_vpw_tx.sv
module tb_vpw_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       quad_mode = 1'b0;
    logic       ext_active = 1'b0;
    logic       bus_in;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       bus_out;
    logic       tx_busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    assign bus_in = bus_out | ext_active;

    always #5 clk = ~clk;

    vpw_tx dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .quad_mode (quad_mode),
        .bus_in    (bus_in),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .bus_out   (bus_out),
        .tx_busy   (tx_busy)
    );

    // segment monitor and tick source in one process
    int   seg_len [64];
    logic seg_lvl [64];
    int   nseg = 0;
    int   ticks = 0;
    int   tick_total = 0;
    int   tail = 0;
    bit   tail_seen = 1'b0;

    initial begin
        logic prev_bus = 1'b0;
        logic busy_prev = 1'b0;
        int   phase = 0;
        forever begin
            @(negedge clk);
            if (us_tick) begin
                ticks++;
                tick_total++;
            end
            if (bus_out !== prev_bus) begin
                if (nseg < 64) begin
                    seg_len[nseg] = ticks;
                    seg_lvl[nseg] = prev_bus;
                end
                nseg++;
                ticks = 0;
                prev_bus = bus_out;
            end
            if (busy_prev && !tx_busy) begin
                tail = ticks;
                tail_seen = 1'b1;
            end
            busy_prev = tx_busy;
            phase = (phase + 1) % 4;
            us_tick = (phase == 0);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int sc(input int us, input logic q);
        return q ? us / 4 : us;
    endfunction

    function automatic int exp_bit(input logic b, input logic act, input logic q);
        return sc((b ^ act) ? 128 : 64, q);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic last);
        logic rdy;
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = d;
        s_last  = last;
        do begin
            rdy = s_ready;
            @(negedge clk);
        end while (!rdy);
        s_valid = 1'b0;
    endtask

    // Sends nb bytes, waits for the frame end and checks every symbol.
    task automatic run_frame(input logic [7:0] d [4], input int nb, input logic q,
                             input bit last_flag, input bit flip_quad,
                             input bit chk_gap, input string req);
        @(negedge clk);
        #1;
        quad_mode = q;
        nseg      = 0;
        tail_seen = 1'b0;
        for (int j = 0; j < nb; j++) begin
            push(d[j], last_flag && (j == nb - 1));
            if (j == 0) begin
                // R2: buffer full right after the accept
                check(s_ready == 1'b0, "R2", "s_ready after accept", s_ready, 0);
            end
        end
        if (flip_quad) begin
            while (!tx_busy) @(negedge clk);
            quad_mode = !q;
        end
        while (!tail_seen) @(negedge clk);
        if (chk_gap) begin
            check(seg_len[0] == sc(300, q) && seg_lvl[0] == 1'b0, "R3",
                  "inter-frame gap ticks", seg_len[0], sc(300, q));
        end
        check(seg_lvl[1] == 1'b1 && seg_len[1] == sc(200, q), "R4",
              "SOF ticks", seg_len[1], sc(200, q));
        check(nseg == 2 + 8 * nb, req, "segment count", nseg, 2 + 8 * nb);
        for (int j = 0; j < nb; j++) begin
            for (int i = 0; i < 8; i++) begin
                logic b;
                logic lv;
                int   k;
                b  = d[j][7 - i];
                lv = logic'(i % 2);
                k  = 2 + 8 * j + i;
                // R5 level alternates from passive; R6 length by value and level
                check(seg_lvl[k] == lv, "R5", "bit level", int'(seg_lvl[k]), int'(lv));
                check(seg_len[k] == exp_bit(b, lv, q), "R6", "bit ticks",
                      seg_len[k], exp_bit(b, lv, q));
            end
        end
        check(tail == sc(280, q), "R7", "EOD+EOF passive ticks", tail, sc(280, q));
    endtask

    localparam logic [8:0] VEC [8] = '{
        9'h0_A5, 9'h0_00, 9'h0_FF, 9'h1_3C,
        9'h1_81, 9'h1_C6, 9'h0_5A, 9'h0_96
    };

    initial begin
        logic [7:0] fb [4];
        logic       prev_q;
        int         t0;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(bus_out == 1'b0, "R1", "bus_out in reset", bus_out, 0);
        check(tx_busy == 1'b0, "R1", "tx_busy in reset", tx_busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
        check(bus_out == 1'b0 && tx_busy == 1'b0, "R1", "idle outputs", bus_out, 0);

        // table walk: single-byte frames, both speeds (R5 R6 R8)
        prev_q = 1'b0;
        for (int v = 0; v < 8; v++) begin
            logic q;
            q = VEC[v][8];
            fb = '{VEC[v][7:0], 8'h00, 8'h00, 8'h00};
            run_frame(fb, 1, q, 1'b1, 1'b0, (v > 0) && !(!prev_q && q), "R8");
            prev_q = q;
        end

        // R9 multi-byte frame, later bytes restart passive
        fb = '{8'hE1, 8'h0F, 8'h6B, 8'h00};
        run_frame(fb, 3, 1'b0, 1'b1, 1'b0, 1'b1, "R9");

        // R9 underrun: byte without last flag and nothing behind it
        fb = '{8'h4D, 8'h00, 8'h00, 8'h00};
        run_frame(fb, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");

        // R8 mode held for the frame although quad_mode flips mid-frame
        fb = '{8'hB2, 8'h00, 8'h00, 8'h00};
        run_frame(fb, 1, 1'b1, 1'b1, 1'b1, 1'b0, "R8");

        // R3 bus held active by another node
        @(negedge clk);
        #1;
        quad_mode  = 1'b0;
        ext_active = 1'b1;
        push(8'h71, 1'b1);
        repeat (2000) @(negedge clk);
        check(tx_busy == 1'b0, "R3", "no start while bus busy", tx_busy, 0);
        check(bus_out == 1'b0, "R3", "bus_out passive while bus busy", bus_out, 0);
        @(negedge clk);
        #1;
        ext_active = 1'b0;
        t0 = tick_total;
        nseg = 0;
        tail_seen = 1'b0;
        while (!bus_out) begin
            @(negedge clk);
            #1;
        end
        check(tick_total - t0 == 300, "R3", "ticks from release to SOF",
              tick_total - t0, 300);
        while (!tail_seen) @(negedge clk);
        check(seg_len[1] == 200, "R4", "SOF ticks after release", seg_len[1], 200);
        check(tail == 280, "R7", "tail after release frame", tail, 280);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule